// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is a single-master I2C engine steered by one-shot command bits. A write of the command field requests exactly one bus sequence: a START, a repeated START, a STOP, the reception of one byte, or the acknowledge bit that follows a received byte. The pending bit stays set while the sequence runs and is cleared by hardware when the sequence ends. A write of the byte buffer while the engine is idle sends that byte and then samples the ninth (acknowledge) bit.

SCL and SDA are open-drain lines. The block only pulls them low through the output enables `scl_oe` and `sda_oe`, where 1 means the line is pulled low. Every SCL phase lasts a number of system clocks set by `baud_div`. The engine handles one sequence at a time. A command or buffer write that arrives while a sequence runs is dropped and raises a sticky collision flag.

Top module: `i2c_cmd_master`

## Requirements
- R1: A command write with bit 0 (START) set, on a released bus, makes SDA fall while SCL is high and then pulls SCL low. Both lines are left pulled low.
- R2: Bit 1 (repeated START) releases SDA while SCL is low, then releases SCL, then pulls SDA low while SCL is high, and then pulls SCL low. No STOP appears on the bus.
- R3: Bit 2 (STOP) pulls SDA low while SCL is low, then releases SCL, then releases SDA while SCL is high. Both lines are left released.
- R4: A buffer write while idle sends `buf_wdata` MSB first, one bit per SCL high pulse. It then releases SDA for a ninth pulse and stores the level sampled there in `ack_status` (1 = no acknowledge, 0 = acknowledged).
- R5: Bit 3 (receive) leaves SDA released for eight SCL pulses. It samples SDA at the end of each high phase, MSB first, and places the byte in `buf_q`.
- R6: Bit 4 (acknowledge) drives the `ack_val` value captured at the command write onto SDA for one SCL pulse: 0 pulls SDA low (ACK) and 1 releases it (NACK).
- R7: SDA changes only while SCL is held low. The only exceptions are the SDA edges of the START and STOP conditions in R1, R2 and R3.
- R8: Every SCL phase of a sequence lasts max(`baud_div`, 2) clock cycles.
- R9: Every sequence ends with a one-cycle `done` pulse. In that same cycle the pending bit in `cmd_pend` reads 0 and `busy` is low.
- R10: While `busy` is high, command writes and buffer writes are ignored. `cmd_pend`, `buf_q` and the running sequence are left untouched, and `wcol` is set. `wcol` stays set until `wcol_clr` is pulsed.
- R11: If a command write sets several bits, only the lowest-numbered bit is accepted. If a command write and a buffer write arrive together while idle, the command runs, the buffer write is dropped and `wcol` is set.
- R12: After reset, `scl_oe`, `sda_oe`, `cmd_pend`, `busy`, `done`, `wcol`, `ack_status` and `buf_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_bits | input | 5 | Command request bits: 0 START, 1 repeated START, 2 STOP, 3 receive, 4 acknowledge |
| ack_val | input | 1 | Value sent by the acknowledge command (0 ACK, 1 NACK) |
| buf_wr | input | 1 | Buffer write strobe; starts a byte transmission |
| buf_wdata | input | 8 | Byte to transmit |
| wcol_clr | input | 1 | Clears the collision flag |
| baud_div | input | DIV_W | Clock cycles per SCL phase (values below 2 act as 2) |
| sda_in | input | 1 | Sensed level of the SDA line |
| cmd_pend | output | 5 | Pending command bits, cleared by hardware |
| buf_q | output | 8 | Byte buffer: last byte transmitted or received |
| ack_status | output | 1 | Acknowledge sampled after the last transmitted byte |
| done | output | 1 | One-cycle end-of-sequence pulse |
| busy | output | 1 | A sequence is running |
| wcol | output | 1 | Sticky write-collision flag |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
A bus model in the bench counts START and STOP edges, captures the transmitted bits on SCL rises, and answers with an ACK, a NACK or a chosen receive byte. This catches a design that sends LSB first, inverts the acknowledge sense or drops the receive byte. A collision is forced by a buffer write and a STOP request in the middle of a byte. A design that queued or obeyed them would corrupt the byte, overwrite the buffer or emit a stray STOP. SCL high time is measured at a divider of 0 and at a larger value, which exposes a missing minimum clamp. A command with two bits set, and a command arriving together with a buffer write, check that exactly one request wins.

// File: rtl/i2c_seq_pkg.sv
`timescale 1ns/1ps
package i2c_seq_pkg;

  localparam int CMD_N  = 5;
  localparam int STEP_W = 5;

  // command bit positions, in priority order
  localparam int C_START  = 0;
  localparam int C_RSTART = 1;
  localparam int C_STOP   = 2;
  localparam int C_RX     = 3;
  localparam int C_ACK    = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_RSTART, ST_STOP, ST_BITS
  } seq_e;

  // clocks per SCL phase, with a floor of two
  function automatic int unsigned phase_len(int unsigned d);
    return (d < 2) ? 2 : d;
  endfunction

  // lowest-numbered set request wins
  function automatic logic [CMD_N-1:0] first_cmd(logic [CMD_N-1:0] b);
    first_cmd = '0;
    for (int i = CMD_N-1; i >= 0; i--)
      if (b[i]) begin
        first_cmd    = '0;
        first_cmd[i] = 1'b1;
      end
  endfunction

  function automatic logic [STEP_W-1:0] last_step(seq_e st, logic [3:0] nbits);
    case (st)
      ST_RSTART: return STEP_W'(3);
      ST_BITS:   return {nbits, 1'b0};
      default:   return STEP_W'(2);
    endcase
  endfunction

  // {scl pulled low, sda pulled low} wanted in a given step
  function automatic logic [1:0] bus_want(seq_e st, logic [STEP_W-1:0] step,
                                          logic [STEP_W-1:0] last, logic bit_hi);
    case (st)
      ST_START:  case (step)
                   5'd0:    return 2'b00;
                   5'd1:    return 2'b01;
                   default: return 2'b11;
                 endcase
      ST_RSTART: case (step)
                   5'd0:    return 2'b10;
                   5'd1:    return 2'b00;
                   5'd2:    return 2'b01;
                   default: return 2'b11;
                 endcase
      ST_STOP:   case (step)
                   5'd0:    return 2'b11;
                   5'd1:    return 2'b01;
                   default: return 2'b00;
                 endcase
      ST_BITS:   if (step == last) return 2'b10;
                 else              return {~step[0], ~bit_hi};
      default:   return 2'b00;
    endcase
  endfunction

  // step in which SDA may move while SCL is high
  function automatic logic is_cond(seq_e st, logic [STEP_W-1:0] step);
    return (st == ST_START  && step == 5'd1) ||
           (st == ST_RSTART && step == 5'd2) ||
           (st == ST_STOP   && step == 5'd2);
  endfunction

endpackage

// File: rtl/i2c_seq_timer.sv
`timescale 1ns/1ps
module i2c_seq_timer import i2c_seq_pkg::*; #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] len_m1;

  assign len_m1 = DIV_W'(phase_len(32'(div)) - 1);
  assign tick   = run && (cnt_q == len_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_seq_shift.sv
`timescale 1ns/1ps
module i2c_seq_shift #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '1;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], sin};
  end
endmodule

// File: rtl/i2c_cmd_master.sv
`timescale 1ns/1ps
module i2c_cmd_master import i2c_seq_pkg::*; #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [4:0]       cmd_bits,
  input  logic             ack_val,
  input  logic             buf_wr,
  input  logic [7:0]       buf_wdata,
  input  logic             wcol_clr,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             sda_in,
  output logic [4:0]       cmd_pend,
  output logic [7:0]       buf_q,
  output logic             ack_status,
  output logic             done,
  output logic             busy,
  output logic             wcol,
  output logic             scl_oe,
  output logic             sda_oe
);
  localparam int SH_W = 9;

  seq_e              state_q;
  logic [STEP_W-1:0] step_q, last_w;
  logic [3:0]        nbits_q;
  logic              is_tx_q, is_rx_q, parked_q, sda_q;
  logic [SH_W-1:0]   sh_q, sh_load;
  logic [CMD_N-1:0]  sel_w;
  logic [1:0]        want_w;

  // named internal events
  logic tick_w, accept_w, tx_go_w, finish_w, shift_w, cond_w, upd_w;

  assign busy     = (state_q != ST_IDLE);
  assign sel_w    = first_cmd(cmd_bits);
  assign accept_w = cmd_wr && !busy && (cmd_bits != '0);
  assign tx_go_w  = buf_wr && !busy && !accept_w;
  assign last_w   = last_step(state_q, nbits_q);
  assign finish_w = busy && tick_w && (step_q == last_w);
  assign shift_w  = tick_w && (state_q == ST_BITS) && step_q[0];
  assign want_w   = bus_want(state_q, step_q, last_w, sh_q[SH_W-1]);
  assign cond_w   = is_cond(state_q, step_q);
  assign upd_w    = busy && !tick_w && (want_w[1] || cond_w);

  assign scl_oe = busy ? want_w[1] : parked_q;
  assign sda_oe = sda_q;

  always_comb begin
    if (tx_go_w)           sh_load = {buf_wdata, 1'b1};
    else if (sel_w[C_ACK]) sh_load = {ack_val, 8'hFF};
    else                   sh_load = '1;
  end

  i2c_seq_timer #(.DIV_W(DIV_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .div  (baud_div),
    .tick (tick_w)
  );

  i2c_seq_shift #(.W(SH_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept_w || tx_go_w),
    .load_val(sh_load),
    .shift   (shift_w),
    .sin     (sda_in),
    .q       (sh_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      step_q     <= '0;
      nbits_q    <= '0;
      is_tx_q    <= 1'b0;
      is_rx_q    <= 1'b0;
      parked_q   <= 1'b0;
      sda_q      <= 1'b0;
      cmd_pend   <= '0;
      buf_q      <= '0;
      ack_status <= 1'b0;
      done       <= 1'b0;
      wcol       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (wcol_clr) wcol <= 1'b0;
      if ((busy && (cmd_wr || buf_wr)) || (buf_wr && accept_w)) wcol <= 1'b1;

      if (accept_w) begin
        cmd_pend <= sel_w;
        step_q   <= '0;
        is_tx_q  <= 1'b0;
        is_rx_q  <= sel_w[C_RX];
        nbits_q  <= sel_w[C_RX] ? 4'd8 : 4'd1;
        if (sel_w[C_START])       state_q <= ST_START;
        else if (sel_w[C_RSTART]) state_q <= ST_RSTART;
        else if (sel_w[C_STOP])   state_q <= ST_STOP;
        else                      state_q <= ST_BITS;
      end else if (tx_go_w) begin
        state_q <= ST_BITS;
        step_q  <= '0;
        nbits_q <= 4'd9;
        is_tx_q <= 1'b1;
        is_rx_q <= 1'b0;
        buf_q   <= buf_wdata;
      end else if (finish_w) begin
        state_q  <= ST_IDLE;
        step_q   <= '0;
        cmd_pend <= '0;
        done     <= 1'b1;
        parked_q <= (state_q != ST_STOP);
        if (is_tx_q) ack_status <= sh_q[0];
        if (is_rx_q) buf_q      <= sh_q[7:0];
      end else if (busy && tick_w) begin
        step_q <= step_q + 1'b1;
      end

      if (upd_w) sda_q <= want_w[0];
    end
  end
endmodule

// File: rtl/i2c_cmd_master_chk.sv
`timescale 1ns/1ps
module i2c_cmd_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic       buf_wr,
  input logic [4:0] cmd_pend,
  input logic       done,
  input logic       busy,
  input logic       wcol,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       finish_w,
  input logic       cond_w
);
  // R9: end of a sequence clears the pending bit and pulses done
  p_self_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    finish_w |=> (cmd_pend == '0) && done && !busy);

  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: at most one command pending
  p_one_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_pend));

  // R10: writes while busy are rejected and flagged
  p_reject_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish_w && (cmd_wr || buf_wr)) |=> $stable(cmd_pend) && wcol);

  // R7: SDA never moves in the same cycle as SCL
  p_sda_scl_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $stable(scl_oe));

  // R7: SDA moves under a released SCL only in a condition step
  p_sda_high_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe != $past(sda_oe)) && !scl_oe) |-> $past(cond_w));
endmodule

bind i2c_cmd_master i2c_cmd_master_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cmd_wr  (cmd_wr),
  .buf_wr  (buf_wr),
  .cmd_pend(cmd_pend),
  .done    (done),
  .busy    (busy),
  .wcol    (wcol),
  .scl_oe  (scl_oe),
  .sda_oe  (sda_oe),
  .finish_w(finish_w),
  .cond_w  (cond_w)
);

// File: tb/i2c_cmd_master_tb.sv
`timescale 1ns/1ps
module i2c_cmd_master_tb;
  localparam int DIV_W = 8;
  localparam int TCK   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic [4:0] cmd_bits = '0;
  logic ack_val = 1'b0;
  logic buf_wr = 1'b0;
  logic [7:0] buf_wdata = '0;
  logic wcol_clr = 1'b0;
  logic [DIV_W-1:0] baud_div = 8'd6;
  logic sda_in;
  logic [4:0] cmd_pend;
  logic [7:0] buf_q;
  logic ack_status, done, busy, wcol, scl_oe, sda_oe;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  i2c_cmd_master #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_bits(cmd_bits),
    .ack_val(ack_val), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .wcol_clr(wcol_clr), .baud_div(baud_div), .sda_in(sda_in),
    .cmd_pend(cmd_pend), .buf_q(buf_q), .ack_status(ack_status),
    .done(done), .busy(busy), .wcol(wcol), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // bus and slave model: 1 = TX, 2 = RX, 3 = ACK
  int   smode = 0;
  int   bitcnt = 0;
  logic slv_ack = 1'b1;
  logic [7:0] rx_src = '0;
  logic [7:0] cap = '0;
  logic ack_seen = 1'b0;
  logic slv_pull;
  int   starts = 0;
  int   stops = 0;
  realtime t_rise = 0;
  realtime hi_len = 0;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || slv_pull);
  assign sda_in = sda_line;

  always @* begin
    slv_pull = 1'b0;
    if (smode == 1 && bitcnt == 8) slv_pull = slv_ack;
    if (smode == 2 && bitcnt < 8)  slv_pull = !rx_src[7 - bitcnt];
  end

  always @(negedge scl_line) begin
    if (smode != 0) bitcnt = bitcnt + 1;
    hi_len = $realtime - t_rise;
  end

  always @(posedge scl_line) begin
    t_rise = $realtime;
    if (smode == 1 && bitcnt < 8) cap = {cap[6:0], sda_line};
    if (smode == 3) ack_seen = sda_line;
  end

  always @(negedge sda_line) if (rst_n && scl_line) starts = starts + 1;
  always @(posedge sda_line) if (rst_n && scl_line) stops = stops + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue_cmd(input logic [4:0] b);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_bits = b;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_bits = '0;
  endtask

  task automatic issue_buf(input logic [7:0] d);
    @(negedge clk);
    buf_wr = 1'b1; buf_wdata = d;
    @(negedge clk);
    buf_wr = 1'b0;
  endtask

  // waits for done and checks the R9 cycle contract
  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R9 done seen", int'(done), 1);
    chk(busy == 1'b0 && cmd_pend == '0, "R9 idle at done", int'({busy, cmd_pend}), 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    chk({scl_oe, sda_oe, busy, done, wcol, ack_status} == '0 && cmd_pend == '0 && buf_q == '0,
        "R12 reset state", int'({scl_oe, sda_oe, busy, done, wcol, ack_status}), 0);
  endtask

  task automatic t_start();
    int s0 = starts;
    issue_cmd(5'b00001);
    chk(cmd_pend == 5'b00001 && busy, "R1 pending while running", int'(cmd_pend), 1);
    wait_done();
    chk(starts == s0 + 1, "R1 START edge", starts - s0, 1);
    chk(scl_oe && sda_oe, "R1 lines left low", int'({scl_oe, sda_oe}), 3);
  endtask

  task automatic t_tx(input logic [7:0] d, input logic ack, input int div);
    int s0 = starts;
    int p0 = stops;
    baud_div = DIV_W'(div);
    slv_ack = ack; bitcnt = 0; smode = 1;
    issue_buf(d);
    wait_done();
    smode = 0;
    chk(cap == d, "R4 bits MSB first", int'(cap), int'(d));
    chk(ack_status == !ack, "R4 ack status", int'(ack_status), int'(!ack));
    chk(buf_q == d, "R4 buffer holds byte", int'(buf_q), int'(d));
    chk(starts == s0 && stops == p0, "R7 no condition in byte", starts - s0 + stops - p0, 0);
    chk(hi_len == real'(((div < 2) ? 2 : div) * TCK), "R8 SCL high time",
        int'(hi_len), ((div < 2) ? 2 : div) * TCK);
  endtask

  task automatic t_rx(input logic [7:0] d, input int div);
    int s0 = starts;
    int p0 = stops;
    baud_div = DIV_W'(div);
    rx_src = d; bitcnt = 0; smode = 2;
    issue_cmd(5'b01000);
    wait_done();
    smode = 0;
    chk(buf_q == d, "R5 received byte", int'(buf_q), int'(d));
    chk(starts == s0 && stops == p0, "R7 no condition in receive", starts - s0 + stops - p0, 0);
    chk(hi_len == real'(((div < 2) ? 2 : div) * TCK), "R8 SCL high time rx",
        int'(hi_len), ((div < 2) ? 2 : div) * TCK);
  endtask

  task automatic t_ack(input logic v);
    ack_val = v; smode = 3; ack_seen = !v;
    issue_cmd(5'b10000);
    ack_val = !v;
    wait_done();
    smode = 0;
    chk(ack_seen == v, "R6 acknowledge value on SDA", int'(ack_seen), int'(v));
  endtask

  task automatic t_rstart();
    int s0 = starts;
    int p0 = stops;
    issue_cmd(5'b00010);
    wait_done();
    chk(starts == s0 + 1 && stops == p0, "R2 repeated START", starts - s0, 1);
    chk(scl_oe && sda_oe, "R2 lines left low", int'({scl_oe, sda_oe}), 3);
  endtask

  task automatic t_stop();
    int p0 = stops;
    issue_cmd(5'b00100);
    wait_done();
    chk(stops == p0 + 1, "R3 STOP edge", stops - p0, 1);
    chk(!scl_oe && !sda_oe, "R3 bus released", int'({scl_oe, sda_oe}), 0);
  endtask

  // R10: writes in the middle of a byte are dropped
  task automatic t_collide();
    int p0 = stops;
    baud_div = 8'd4;
    slv_ack = 1'b0; bitcnt = 0; smode = 1;
    issue_buf(8'h5A);
    repeat (6) @(negedge clk);
    buf_wr = 1'b1; buf_wdata = 8'hFF; cmd_wr = 1'b1; cmd_bits = 5'b00100;
    @(negedge clk);
    buf_wr = 1'b0; cmd_wr = 1'b0; cmd_bits = '0;
    chk(wcol == 1'b1, "R10 collision flagged", int'(wcol), 1);
    chk(cmd_pend == '0 && buf_q == 8'h5A && busy, "R10 state untouched",
        int'(buf_q), 8'h5A);
    wait_done();
    smode = 0;
    chk(cap == 8'h5A && stops == p0, "R10 byte intact, no STOP", int'(cap), 8'h5A);
    chk(ack_status == 1'b1, "R4 NACK recorded", int'(ack_status), 1);
    chk(wcol == 1'b1, "R10 flag sticky", int'(wcol), 1);
    @(negedge clk); wcol_clr = 1'b1;
    @(negedge clk); wcol_clr = 1'b0;
    chk(wcol == 1'b0, "R10 flag cleared", int'(wcol), 0);
  endtask

  // R11: priority among simultaneous requests
  task automatic t_multi();
    int s0 = starts;
    int p0 = stops;
    issue_cmd(5'b00110);
    chk(cmd_pend == 5'b00010, "R11 lowest bit wins", int'(cmd_pend), 2);
    wait_done();
    chk(starts == s0 + 1 && stops == p0, "R11 only repeated START ran", stops - p0, 0);
    p0 = stops;
    @(negedge clk);
    cmd_wr = 1'b1; cmd_bits = 5'b00100; buf_wr = 1'b1; buf_wdata = 8'h99;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_bits = '0; buf_wr = 1'b0;
    chk(cmd_pend == 5'b00100 && wcol, "R11 command beats buffer", int'({wcol, cmd_pend}), 8'h24);
    wait_done();
    chk(buf_q != 8'h99 && stops == p0 + 1, "R11 buffer write dropped", int'(buf_q), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_start();
    t_tx(8'hA5, 1'b1, 6);
    t_rx(8'h3C, 0);
    t_ack(1'b0);
    t_rstart();
    t_tx(8'h81, 1'b1, 3);
    t_rx(8'hC6, 5);
    t_ack(1'b1);
    t_stop();
    t_start();
    t_collide();
    t_multi();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule